// File: doc/BRIEF.md
# Segmented Scan Chain Controller

This block runs a scan chain that is cut into several equal segments of flip-flops. Every segment listens to one serial input line, and their outputs are merged onto one serial output line. The controller clocks only one segment at a time while a pattern is shifted, so the shift activity at any moment is confined to that segment. Each segment also has its own capture enable, so launch and capture pulses can be aimed at any group of segments. Two-pattern launch-on-capture tests can therefore launch in one segment and capture in another, or pulse every segment together as an unsegmented chain would.

A test starts with a single-cycle start request, which carries two capture masks and two flags. The first flag skips the load phase. The second flag enables the second capture step. The controller then runs three phases. First it loads the segments in ascending order, L shift cycles each. Next it applies one or two single-cycle capture steps. Finally it unloads the segments in the same order. During the unload the serial input keeps shifting in, so the unload can also load the next pattern. The start that follows then sets the skip flag. The segment flip-flops are modelled inside the block. A combinational stand-in replaces the circuit under test.

Top module: `seg_scan_ctrl`

## Requirements
- R1: After synchronous reset, the following are all low: busy, done, every shift, capture and drive enable, and the serial output. Every segment flip-flop holds 0.
- R2: After an accepted start with the skip flag clear, segment 0 shifts for L cycles, then segment 1, and so on up to segment N-1. At most one shift enable is high in any cycle. Every segment that is not enabled holds its contents.
- R3: During a shift cycle, the serial output equals bit L-1 of the selected segment. That bit is valid in the same cycle in which the serial input bit is accepted. On that edge the segment moves each bit up by one position and takes the input into bit 0. The drive enables equal the shift enables. When no drive enable is high, the serial output is 0.
- R4: The cycle after the last shift of the load is a capture cycle. In it the capture enables equal step mask 0, latched at start. If the two-step flag was set, the next cycle is a capture cycle with step mask 1. No shift enable is high in a capture cycle.
- R5: In a capture cycle, every segment whose capture enable is high loads the stand-in response. All other segments hold. Response bit i is chain bit i XOR chain bit (i+1) mod N*L. Chain bit s*L+k is bit k of segment s. A second step sees the values written by the first step.
- R6: After the last capture step, the segments unload in ascending order, L cycles each. The serial input is shifted in at the same time as the segment's old contents are shifted out.
- R7: A start with the skip flag set goes directly to step 0 of the capture on the next cycle. The segment contents are kept.
- R8: Busy is high from the cycle after an accepted start through the last unload shift cycle. Done is high for exactly the one following cycle, and busy is low in that cycle.
- R9: A start request while busy is high is ignored. The masks and flags latched at the accepted start keep steering the test.
- R10: A start is accepted when busy is low, and this includes the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| skip_load_i | input | 1 | Start with the capture phase and skip the load |
| two_step_i | input | 1 | Apply the second capture step |
| step0_mask_i | input | N | Segments that receive capture step 0 |
| step1_mask_i | input | N | Segments that receive capture step 1 |
| scan_in_i | input | 1 | Shared serial input |
| scan_out_o | output | 1 | Shared serial output |
| seg_shift_en_o | output | N | Shift clock enable for each segment |
| seg_capture_en_o | output | N | Capture clock enable for each segment |
| seg_drive_en_o | output | N | Output drive enable for each segment |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |

## Verification
A segment index or bit counter that is off by one shows at once on the enable outputs. The shift enable changes at the wrong cycle, or it points at a neighbouring segment. A segment that shifts or captures while it is not selected gives no sign at the enables. It shows at the serial output only when that segment is next unloaded, up to N*L+2 cycles later. The bench therefore compares every output bit of every unload with its own model of the chain. A wrong latched mask shows in the capture cycle, as a wrong capture-enable pattern. It shows again later, as unloaded data that does not match the model.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    // The phases of one test
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOAD   = 3'd1,
        PH_CAP0   = 3'd2,
        PH_CAP1   = 3'd3,
        PH_UNLOAD = 3'd4,
        PH_DONE   = 3'd5
    } scan_phase_e;

    // Flags that are latched when a start is accepted
    typedef struct packed {
        logic skip_load;
        logic two_step;
    } test_flags_t;

    // The phase that follows an accepted start
    function automatic scan_phase_e entry_phase(input test_flags_t f);
        return f.skip_load ? PH_CAP0 : PH_LOAD;
    endfunction

    // The phase that follows capture step 0
    function automatic scan_phase_e after_step0(input test_flags_t f);
        return f.two_step ? PH_CAP1 : PH_UNLOAD;
    endfunction

    function automatic logic is_shift_phase(input scan_phase_e p);
        return (p == PH_LOAD) || (p == PH_UNLOAD);
    endfunction

endpackage

// File: rtl/scan_segment.sv
module scan_segment #(
    parameter int L = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en_i,
    input  logic         cap_en_i,
    input  logic         sin_i,
    input  logic [L-1:0] cap_data_i,
    output logic [L-1:0] data_o,
    output logic         sout_o
);

    logic [L-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (shift_en_i) begin
            data_q <= {data_q[L-2:0], sin_i};
        end else if (cap_en_i) begin
            data_q <= cap_data_i;
        end
    end

    assign data_o = data_q;
    assign sout_o = data_q[L-1];

    AST_SEG_HOLDS_WHEN_GATED: assert property (@(posedge clk) disable iff (rst)
        (!shift_en_i && !cap_en_i) |=> $stable(data_q)); // R2

    AST_SEG_SHIFT_INTAKE: assert property (@(posedge clk) disable iff (rst)
        shift_en_i |=> (data_q[0] == $past(sin_i))); // R3

endmodule

// File: rtl/cut_stub.sv
module cut_stub #(
    parameter int W = 12
) (
    input  logic [W-1:0] chain_i,
    output logic [W-1:0] resp_o
);

    for (genvar i = 0; i < W; i++) begin : g_resp
        assign resp_o[i] = chain_i[i] ^ chain_i[(i + 1) % W];
    end

endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
    import seg_scan_pkg::*;
#(
    parameter int N = 3,
    parameter int L = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  test_flags_t flags_i,
    input  logic [N-1:0] step0_i,
    input  logic [N-1:0] step1_i,
    output logic [N-1:0] shift_en_o,
    output logic [N-1:0] cap_en_o,
    output logic        busy_o,
    output logic        done_o
);

    localparam int CW = (L > 1) ? $clog2(L) : 1;
    localparam int SW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(L - 1);
    localparam logic [SW-1:0] LAST_SEG = SW'(N - 1);

    scan_phase_e  phase_q;
    logic [SW-1:0] seg_q;
    logic [CW-1:0] bit_q;
    test_flags_t  flags_q;
    logic [N-1:0] step0_q;
    logic [N-1:0] step1_q;

    logic last_bit;
    logic last_seg;
    logic can_start;

    assign last_bit  = (bit_q == LAST_BIT);
    assign last_seg  = (seg_q == LAST_SEG);
    assign can_start = (phase_q == PH_IDLE) || (phase_q == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            seg_q   <= '0;
            bit_q   <= '0;
            flags_q <= '0;
            step0_q <= '0;
            step1_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_DONE: begin
                    if (start_i) begin
                        flags_q <= flags_i;
                        step0_q <= step0_i;
                        step1_q <= step1_i;
                        seg_q   <= '0;
                        bit_q   <= '0;
                        phase_q <= entry_phase(flags_i);
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_LOAD, PH_UNLOAD: begin
                    if (last_bit) begin
                        bit_q <= '0;
                        if (last_seg) begin
                            seg_q   <= '0;
                            phase_q <= (phase_q == PH_LOAD) ? PH_CAP0 : PH_DONE;
                        end else begin
                            seg_q <= SW'(seg_q + 1'b1);
                        end
                    end else begin
                        bit_q <= CW'(bit_q + 1'b1);
                    end
                end
                PH_CAP0: phase_q <= after_step0(flags_q);
                PH_CAP1: phase_q <= PH_UNLOAD;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        shift_en_o = '0;
        cap_en_o   = '0;
        if (is_shift_phase(phase_q)) begin
            shift_en_o = N'(1) << seg_q;
        end
        if (phase_q == PH_CAP0) begin
            cap_en_o = step0_q;
        end else if (phase_q == PH_CAP1) begin
            cap_en_o = step1_q;
        end
    end

    assign busy_o = !can_start;
    assign done_o = (phase_q == PH_DONE);

    AST_SHIFT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(shift_en_o)); // R2

    AST_NO_SHIFT_IN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cap_en_o != '0) |-> (shift_en_o == '0)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R8

    AST_MASKS_STABLE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ($stable(step0_q) && $stable(step1_q) && $stable(flags_q))); // R9

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o); // R10

endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
    import seg_scan_pkg::*;
#(
    parameter int N = 3,
    parameter int L = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         skip_load_i,
    input  logic         two_step_i,
    input  logic [N-1:0] step0_mask_i,
    input  logic [N-1:0] step1_mask_i,
    input  logic         scan_in_i,
    output logic         scan_out_o,
    output logic [N-1:0] seg_shift_en_o,
    output logic [N-1:0] seg_capture_en_o,
    output logic [N-1:0] seg_drive_en_o,
    output logic         busy_o,
    output logic         done_o
);

    localparam int W = N * L;

    test_flags_t  flags;
    logic [N-1:0] shift_en;
    logic [N-1:0] cap_en;
    logic [N-1:0] seg_sout;
    logic [W-1:0] chain;
    logic [W-1:0] resp;

    assign flags.skip_load = skip_load_i;
    assign flags.two_step  = two_step_i;

    seg_sequencer #(.N(N), .L(L)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .flags_i   (flags),
        .step0_i   (step0_mask_i),
        .step1_i   (step1_mask_i),
        .shift_en_o(shift_en),
        .cap_en_o  (cap_en),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    for (genvar g = 0; g < N; g++) begin : g_seg
        scan_segment #(.L(L)) i_segment (
            .clk       (clk),
            .rst       (rst),
            .shift_en_i(shift_en[g]),
            .cap_en_i  (cap_en[g]),
            .sin_i     (scan_in_i),
            .cap_data_i(resp[g*L +: L]),
            .data_o    (chain[g*L +: L]),
            .sout_o    (seg_sout[g])
        );
    end

    cut_stub #(.W(W)) i_stub (
        .chain_i(chain),
        .resp_o (resp)
    );

    // Each segment drives the shared line only while it is selected
    always_comb begin
        scan_out_o = 1'b0;
        for (int s = 0; s < N; s++) begin
            scan_out_o = scan_out_o | (seg_sout[s] & shift_en[s]);
        end
    end

    assign seg_shift_en_o   = shift_en;
    assign seg_capture_en_o = cap_en;
    assign seg_drive_en_o   = shift_en;

    AST_OUT_QUIET_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        (seg_drive_en_o == '0) |-> (scan_out_o == 1'b0)); // R3

    AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(seg_drive_en_o)); // R3

endmodule

// File: tb/test_seg_scan_ctrl.sv
module test_seg_scan_ctrl;

    localparam int NS = 3;
    localparam int LS = 4;
    localparam int WS = NS * LS;

    typedef struct packed {
        logic          skip;
        logic          two;
        logic [NS-1:0] s0;
        logic [NS-1:0] s1;
        logic [7:0]    seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 3'b001, 3'b010, 8'hA5},
        '{1'b1, 1'b1, 3'b010, 3'b100, 8'h3C},
        '{1'b0, 1'b1, 3'b111, 3'b111, 8'h71},
        '{1'b1, 1'b1, 3'b100, 3'b111, 8'h0F},
        '{1'b0, 1'b0, 3'b011, 3'b000, 8'hD2},
        '{1'b1, 1'b1, 3'b000, 3'b001, 8'h96}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic skip_load = 1'b0;
    logic two_step = 1'b0;
    logic [NS-1:0] step0 = '0;
    logic [NS-1:0] step1 = '0;
    logic scan_in = 1'b0;
    logic scan_out;
    logic [NS-1:0] shift_en;
    logic [NS-1:0] cap_en;
    logic [NS-1:0] drive_en;
    logic busy;
    logic done;

    int checks = 0;
    int fails = 0;
    logic [7:0] lf;
    logic [LS-1:0] m [NS];

    always #10 clk = ~clk;

    seg_scan_ctrl #(.N(NS), .L(LS)) i_seg_scan_ctrl (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start),
        .skip_load_i     (skip_load),
        .two_step_i      (two_step),
        .step0_mask_i    (step0),
        .step1_mask_i    (step1),
        .scan_in_i       (scan_in),
        .scan_out_o      (scan_out),
        .seg_shift_en_o  (shift_en),
        .seg_capture_en_o(cap_en),
        .seg_drive_en_o  (drive_en),
        .busy_o          (busy),
        .done_o          (done)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic next_bit();
        logic b;
        b  = lf[0];
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        return b;
    endfunction

    // The model of one capture step, written from R5
    task automatic model_capture(input logic [NS-1:0] mask);
        logic [WS-1:0] flat;
        logic [WS-1:0] r;
        for (int s = 0; s < NS; s++) flat[s*LS +: LS] = m[s];
        for (int i = 0; i < WS; i++) r[i] = flat[i] ^ flat[(i + 1) % WS];
        for (int s = 0; s < NS; s++) if (mask[s]) m[s] = r[s*LS +: LS];
    endtask

    task automatic shift_phase(input string req, input bit inject);
        for (int s = 0; s < NS; s++) begin
            for (int b = 0; b < LS; b++) begin
                logic bit_in;
                bit_in = next_bit();
                scan_in = bit_in;
                if (inject && s == 0 && b == 1) begin
                    start = 1'b1; skip_load = 1'b1; two_step = 1'b0;
                    step0 = 3'b100; step1 = 3'b100;
                end else begin
                    start = 1'b0;
                end
                #1;
                check(shift_en == NS'(1 << s), req, shift_en, 1 << s);
                check(drive_en == shift_en, "R3", drive_en, shift_en);
                check(scan_out == m[s][LS-1], "R3", scan_out, m[s][LS-1]);
                check(cap_en == '0, "R4", cap_en, 0);
                m[s] = {m[s][LS-2:0], bit_in};
                @(negedge clk);
            end
        end
        start = 1'b0;
    endtask

    task automatic cap_step(input logic [NS-1:0] mask);
        check(cap_en == mask, "R4", cap_en, mask);
        check(shift_en == '0, "R4", shift_en, 0);
        check(scan_out == 1'b0, "R3", scan_out, 0);
        check(busy == 1'b1, "R8", busy, 1);
        model_capture(mask);
        @(negedge clk);
    endtask

    task automatic run_test(input vec_t v, input bit inject);
        lf = v.seed;
        start = 1'b1; skip_load = v.skip; two_step = v.two;
        step0 = v.s0; step1 = v.s1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", busy, 1);
        if (v.skip) begin
            check(shift_en == '0, "R7", shift_en, 0);
        end else begin
            shift_phase("R2", inject);
        end
        cap_step(v.s0);
        if (v.two) cap_step(v.s1);
        shift_phase("R6", 1'b0);
        check(done == 1'b1, "R8", done, 1);
        check(busy == 1'b0, "R8", busy, 0);
        check(shift_en == '0, "R8", shift_en, 0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) m[s] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: the state after reset
        check(busy == 1'b0, "R1", busy, 0);
        check(done == 1'b0, "R1", done, 0);
        check(shift_en == '0 && cap_en == '0 && drive_en == '0, "R1", {shift_en, cap_en, drive_en}, 0);
        check(scan_out == 1'b0, "R1", scan_out, 0);
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R1", busy, 0);

        // The table walk: load order, capture modes and skip-load, with each unload checked against the model
        for (int v = 0; v < NV; v++) begin
            run_test(VECS[v], 1'b0);
            @(negedge clk);
            check(done == 1'b0, "R8", done, 0);
        end

        // R9: a start while busy must not replace the latched masks
        run_test('{1'b0, 1'b1, 3'b001, 3'b010, 8'h5A}, 1'b1);
        @(negedge clk);

        // R10: a start in the same cycle as done is accepted
        run_test('{1'b0, 1'b0, 3'b110, 3'b000, 8'h44}, 1'b0);
        start = 1'b1; skip_load = 1'b1; two_step = 1'b0; step0 = 3'b001; step1 = 3'b000;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10", busy, 1);
        check(cap_en == 3'b001, "R10", cap_en, 3'b001);
        model_capture(3'b001);
        @(negedge clk);
        lf = 8'h21;
        shift_phase("R6", 1'b0);
        check(done == 1'b1, "R10", done, 1);
        @(negedge clk);

        // R1: a reset in the middle of a load returns the block to idle
        start = 1'b1; skip_load = 1'b0; two_step = 1'b1; step0 = 3'b111; step1 = 3'b111;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0 && shift_en == '0 && cap_en == '0, "R1", {busy, shift_en, cap_en}, 0);
        for (int s = 0; s < NS; s++) m[s] = '0;
        run_test('{1'b0, 1'b0, 3'b010, 3'b000, 8'h3B}, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule